// File: doc/BRIEF.md
# SPI Operation-Program Sequencer

This block runs a short microprogram of eight byte-wide operation codes that steer a SPI shift engine. Each code is fetched, decoded on its upper nibble and executed, and then the slot index moves on or jumps. The operations are responder select and deselect, the N1 and N2 shift segments, a masked compare branch on received data, two counted loop branches, a skip, and stop. The shift engine sits behind a request/acknowledge handshake. It can answer with a stall instead of an acknowledge, and the program then halts in a wait state until data becomes available.

A run starts on a transmit-data write. A read of received data also starts a run, but only while the shifter is waiting. A run that resumes after a halt continues at the slot where it halted. A run that starts from the idle sequencer state begins at slot 0. When an N1 shift is followed directly by an N2 shift, the two segments go out as one frame.

Top module: `spi_opseq`

## Requirements
- R1: The sequencer starts a run in three cases: a `tdr_wr` pulse while it is halted, an `rdr_rd` pulse while it is halted and `shf_state` = 4 (wait), or both together. In the cycle after the trigger `seq_state` becomes 1 (decode) and `seq_err` is 0. `seq_index` becomes 0 only if `seq_state` was 0 (idle); otherwise the index is kept. The `seq_state` codes are 0 idle, 1 decode, 2 execute and 3 index-step.
- R2: `op_prog` slot k is bits [8k+7:8k]. Only the upper nibble selects the operation: 0x0 stop, 0x1 select, 0x3 Shift-N1, 0x4 Shift-N2, 0x6 compare branch, 0xC skip, 0xE loop 1, 0xF loop 2. Each operation takes one decode cycle, then execute (which holds until the engine answers a shift), then one index-step cycle.
- R3: Select with operand 0 clears `resp_sel` and sets `shf_state` to 5 (done). Operand 1 sets `resp_sel`, sets `shf_state` to 1 (start) and marks the next frame as first. Any other operand is an error. The `shf_state` codes are 0 idle, 1 start, 2 N1, 3 N2, 4 wait and 5 done.
- R4: Stop clears both loop counters, sets `shf_state` to 0 and `seq_state` to 0, and ends the run.
- R5: Errors are an undefined nibble, a bad select operand, a Shift-N1 while `shf_state` is 0 or 5, and a Shift-N2 with no Shift-N1 done since the last valid select. An error sets `seq_err` and sets `shf_state` and `seq_state` to 0.
- R6: A Shift-N1 whose next slot is a Shift-N2 issues no request. It is held and sent together with the N2 as one request of `eng_kind` 3. A lone N1 has kind 1 and a lone N2 has kind 2.
- R7: `eng_first` is high on the first request after a valid select. `eng_last` is high when the slot after the shifting slot is exactly 0x10. Slot 7 has no next slot.
- R8: The compare branch 0x6t with `rdr_full` high pulses `rdr_clr`. It steps to the next slot if `(rdr_low ^ cmp_val) & ~cmp_mask` is zero, and jumps to slot t[2:0] otherwise.
- R9: The compare branch with `rdr_full` low sets `shf_state` to 4 and halts the run, keeping the index.
- R10: Loop 0xEt (counter 1, limit `loop_lim[3:0]`) and loop 0xFt (counter 2, limit `loop_lim[7:4]`) jump to t[2:0] and increment their counter while it differs from the limit. When the counter equals the limit they step to the next slot.
- R11: A shift request acknowledged by `eng_ack` sets `shf_state` to 2 or 3 and steps the index. `eng_stall` without `eng_ack` sets `shf_state` to 4 and halts the run. A later start re-executes the same slot.
- R12: Stepping past slot 7 ends the run with `seq_state` 0 and `seq_index` 0.
- R13: The skip operation 0xC only steps the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_prog | input | 64 | Eight operation slots, slot 0 in the low byte |
| tdr_wr | input | 1 | Transmit data written (start) |
| rdr_rd | input | 1 | Received data read (resume when waiting) |
| rdr_full | input | 1 | Received data register holds unread data |
| rdr_low | input | 16 | Low 16 bits of received data |
| cmp_val | input | 16 | Compare-branch match value |
| cmp_mask | input | 16 | Compare-branch mask, 1 = bit ignored |
| loop_lim | input | 8 | Loop limits: [3:0] loop 1, [7:4] loop 2 |
| eng_ack | input | 1 | Shift engine accepted the frame |
| eng_stall | input | 1 | Shift engine cannot proceed |
| eng_req | output | 1 | Frame request to the shift engine |
| eng_kind | output | 2 | 1 N1, 2 N2, 3 N1+N2 merged |
| eng_first | output | 1 | First frame after select |
| eng_last | output | 1 | Last frame before deselect |
| rdr_clr | output | 1 | Clear received-data-full pulse |
| resp_sel | output | 1 | Responder 1 selected |
| seq_state | output | 2 | Sequencer FSM state |
| shf_state | output | 3 | Shifter FSM state |
| seq_index | output | 3 | Current slot index |
| seq_err | output | 1 | Sequencer error |

## Verification
The bench builds the block with its default parameters: eight slots, byte-wide codes, 4-bit loop counters and a 16-bit compare field. With these values the bench can write the whole program as one 64-bit word. The small loop limits keep iterated programs short while still exercising jump, fall-through and counter clearing at stop. The 16-bit compare field lets single-bit mask patterns turn a mismatch into a match.

// File: rtl/spi_opseq_pkg.sv
package spi_opseq_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_DECODE = 2'd1,
        SQ_EXEC   = 2'd2,
        SQ_STEP   = 2'd3
    } seq_t;

    typedef enum logic [2:0] {
        SH_IDLE  = 3'd0,
        SH_START = 3'd1,
        SH_N1    = 3'd2,
        SH_N2    = 3'd3,
        SH_WAIT  = 3'd4,
        SH_DONE  = 3'd5
    } shf_t;

    typedef enum logic [3:0] {
        OP_STOP, OP_SEL, OP_N1, OP_N2, OP_CMP, OP_SKIP, OP_LOOP1, OP_LOOP2, OP_BAD
    } opk_t;

    localparam logic [1:0] KIND_N1  = 2'd1;
    localparam logic [1:0] KIND_N2  = 2'd2;
    localparam logic [1:0] KIND_MRG = 2'd3;
endpackage

// File: rtl/spi_opseq_dec.sv
module spi_opseq_dec
    import spi_opseq_pkg::*;
#(
    parameter int OPW = 8
) (
    input  logic [OPW-1:0] op,
    output opk_t           kind
);
    always_comb begin
        case (op[OPW-1 -: 4])
            4'h0:    kind = OP_STOP;
            4'h1:    kind = OP_SEL;
            4'h3:    kind = OP_N1;
            4'h4:    kind = OP_N2;
            4'h6:    kind = OP_CMP;
            4'hC:    kind = OP_SKIP;
            4'hE:    kind = OP_LOOP1;
            4'hF:    kind = OP_LOOP2;
            default: kind = OP_BAD;
        endcase
    end
endmodule

// File: rtl/spi_opseq_match.sv
module spi_opseq_match #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] val,
    input  logic [DW-1:0] mask,
    output logic          hit
);
    always_comb hit = ((data ^ val) & ~mask) == '0;
endmodule

// File: rtl/spi_opseq_loops.sv
module spi_opseq_loops #(
    parameter int NLOOP = 2,
    parameter int CW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [NLOOP-1:0]    bump,
    input  logic [NLOOP*CW-1:0] lim,
    output logic [NLOOP-1:0]    hit
);
    for (genvar g = 0; g < NLOOP; g++) begin : g_cnt
        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (clr)          cnt_d = '0;
            else if (bump[g]) cnt_d = cnt_q + 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign hit[g] = (cnt_q == lim[g*CW +: CW]);
    end
endmodule

// File: rtl/spi_opseq.sv
module spi_opseq
    import spi_opseq_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int OPW   = 8,
    parameter int CW    = 4,
    parameter int DW    = 16,
    localparam int IDXW = $clog2(SLOTS),
    localparam int PW   = SLOTS * OPW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PW-1:0]   op_prog,
    input  logic            tdr_wr,
    input  logic            rdr_rd,
    input  logic            rdr_full,
    input  logic [DW-1:0]   rdr_low,
    input  logic [DW-1:0]   cmp_val,
    input  logic [DW-1:0]   cmp_mask,
    input  logic [2*CW-1:0] loop_lim,
    input  logic            eng_ack,
    input  logic            eng_stall,
    output logic            eng_req,
    output logic [1:0]      eng_kind,
    output logic            eng_first,
    output logic            eng_last,
    output logic            rdr_clr,
    output logic            resp_sel,
    output logic [1:0]      seq_state,
    output logic [2:0]      shf_state,
    output logic [IDXW-1:0] seq_index,
    output logic            seq_err
);
    localparam logic [OPW-1:0] DESEL_OP = OPW'(1) << (OPW - 4);

    typedef struct packed {
        logic            run;
        seq_t            seq;
        shf_t            shf;
        logic [IDXW-1:0] idx;
        logic            err;
        logic            sel;
        logic            first;
        logic            n1;
        logic            held;
        logic [OPW-1:0]  op;
    } st_t;

    st_t st_d, st_q;

    logic [IDXW-1:0] nidx;
    logic [OPW-1:0]  cur_op, nxt_op;
    logic            nxt_valid, merge, shf_ok, cmp_hit, loop_clr, trig;
    logic [1:0]      loop_bump, loop_hit;
    opk_t            kind, nxt_kind;

    assign nidx      = st_q.idx + 1'b1;
    assign nxt_valid = st_q.idx != IDXW'(SLOTS - 1);
    assign cur_op    = op_prog[int'(st_q.idx) * OPW +: OPW];
    assign nxt_op    = op_prog[int'(nidx) * OPW +: OPW];

    spi_opseq_dec #(.OPW(OPW)) u_dec_cur (.op(st_q.op), .kind(kind));
    spi_opseq_dec #(.OPW(OPW)) u_dec_nxt (.op(nxt_op),  .kind(nxt_kind));

    spi_opseq_match #(.DW(DW)) u_match (
        .data(rdr_low), .val(cmp_val), .mask(cmp_mask), .hit(cmp_hit)
    );

    spi_opseq_loops #(.NLOOP(2), .CW(CW)) u_loops (
        .clk(clk), .rst_n(rst_n), .clr(loop_clr), .bump(loop_bump),
        .lim(loop_lim), .hit(loop_hit)
    );

    assign merge  = nxt_valid && (nxt_kind == OP_N2);
    assign shf_ok = (st_q.shf != SH_IDLE) && (st_q.shf != SH_DONE);
    assign trig   = tdr_wr || (rdr_rd && st_q.shf == SH_WAIT);

    always_comb begin
        logic go_inc, go_jmp, fail;
        st_d      = st_q;
        loop_clr  = 1'b0;
        loop_bump = '0;
        go_inc    = 1'b0;
        go_jmp    = 1'b0;
        fail      = 1'b0;
        if (!st_q.run) begin
            if (trig) begin
                st_d.run = 1'b1;
                st_d.err = 1'b0;
                st_d.seq = SQ_DECODE;
                if (st_q.seq == SQ_IDLE) st_d.idx = '0;
            end
        end else begin
            case (st_q.seq)
                SQ_DECODE: begin
                    st_d.op  = cur_op;
                    st_d.seq = SQ_EXEC;
                end
                SQ_EXEC: begin
                    case (kind)
                        OP_STOP: begin
                            loop_clr = 1'b1;
                            st_d.shf = SH_IDLE;
                            st_d.seq = SQ_IDLE;
                            st_d.run = 1'b0;
                        end
                        OP_SEL: begin
                            if (st_q.op[3:0] == 4'd0) begin
                                st_d.sel = 1'b0;
                                st_d.shf = SH_DONE;
                                go_inc   = 1'b1;
                            end else if (st_q.op[3:0] == 4'd1) begin
                                st_d.sel   = 1'b1;
                                st_d.shf   = SH_START;
                                st_d.first = 1'b1;
                                st_d.n1    = 1'b0;
                                st_d.held  = 1'b0;
                                go_inc     = 1'b1;
                            end else begin
                                fail = 1'b1;
                            end
                        end
                        OP_N1: begin
                            if (!shf_ok) begin
                                fail = 1'b1;
                            end else if (merge) begin
                                st_d.held = 1'b1;
                                st_d.n1   = 1'b1;
                                st_d.shf  = SH_N1;
                                go_inc    = 1'b1;
                            end else if (eng_ack) begin
                                st_d.n1    = 1'b1;
                                st_d.first = 1'b0;
                                st_d.shf   = SH_N1;
                                go_inc     = 1'b1;
                            end else if (eng_stall) begin
                                st_d.shf = SH_WAIT;
                                st_d.run = 1'b0;
                            end
                        end
                        OP_N2: begin
                            if (!st_q.n1) begin
                                fail = 1'b1;
                            end else if (eng_ack) begin
                                st_d.held  = 1'b0;
                                st_d.first = 1'b0;
                                st_d.shf   = SH_N2;
                                go_inc     = 1'b1;
                            end else if (eng_stall) begin
                                st_d.shf = SH_WAIT;
                                st_d.run = 1'b0;
                            end
                        end
                        OP_CMP: begin
                            if (!rdr_full) begin
                                st_d.shf = SH_WAIT;
                                st_d.run = 1'b0;
                            end else if (cmp_hit) begin
                                go_inc = 1'b1;
                            end else begin
                                go_jmp = 1'b1;
                            end
                        end
                        OP_SKIP: go_inc = 1'b1;
                        OP_LOOP1, OP_LOOP2: begin
                            if (!loop_hit[kind == OP_LOOP2]) begin
                                loop_bump[kind == OP_LOOP2] = 1'b1;
                                go_jmp = 1'b1;
                            end else begin
                                go_inc = 1'b1;
                            end
                        end
                        default: fail = 1'b1;
                    endcase
                end
                default: st_d.seq = SQ_DECODE;
            endcase
        end
        if (fail) begin
            st_d.err = 1'b1;
            st_d.shf = SH_IDLE;
            st_d.seq = SQ_IDLE;
            st_d.run = 1'b0;
        end
        if (go_jmp) begin
            st_d.idx = st_q.op[IDXW-1:0];
            st_d.seq = SQ_STEP;
        end
        if (go_inc) begin
            if (nxt_valid) begin
                st_d.idx = nidx;
                st_d.seq = SQ_STEP;
            end else begin
                st_d.idx = '0;
                st_d.seq = SQ_IDLE;
                st_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        logic in_exec;
        in_exec   = st_q.run && (st_q.seq == SQ_EXEC);
        eng_req   = in_exec && (((kind == OP_N1) && shf_ok && !merge) ||
                                ((kind == OP_N2) && st_q.n1));
        eng_kind  = (kind == OP_N2) ? (st_q.held ? KIND_MRG : KIND_N2) : KIND_N1;
        eng_first = st_q.first;
        eng_last  = nxt_valid && (nxt_op == DESEL_OP);
        rdr_clr   = in_exec && (kind == OP_CMP) && rdr_full;
    end

    assign resp_sel  = st_q.sel;
    assign seq_state = st_q.seq;
    assign shf_state = st_q.shf;
    assign seq_index = st_q.idx;
    assign seq_err   = st_q.err;
endmodule

// File: rtl/spi_opseq_chk.sv
module spi_opseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tdr_wr,
    input logic       rdr_full,
    input logic       eng_ack,
    input logic       eng_stall,
    input logic       eng_req,
    input logic       rdr_clr,
    input logic       resp_sel,
    input logic [1:0] seq_state,
    input logic [2:0] shf_state,
    input logic [2:0] seq_index,
    input logic       seq_err
);
    a_r11_req_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> seq_state == 2'd2);

    a_r5_err_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_err) |-> (seq_state == 2'd0 && shf_state == 3'd0));

    a_r1_idle_start: assert property (@(posedge clk) disable iff (!rst_n)
        (tdr_wr && seq_state == 2'd0) |=> (seq_index == 3'd0 && seq_state == 2'd1 && !seq_err));

    a_r8_clr_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        rdr_clr |-> rdr_full);

    a_r11_stall_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_stall && !eng_ack) |=> shf_state == 3'd4);

    a_r3_done_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (shf_state == 3'd5) |-> !resp_sel);
endmodule

bind spi_opseq spi_opseq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tdr_wr(tdr_wr), .rdr_full(rdr_full),
    .eng_ack(eng_ack), .eng_stall(eng_stall), .eng_req(eng_req),
    .rdr_clr(rdr_clr), .resp_sel(resp_sel), .seq_state(seq_state),
    .shf_state(shf_state), .seq_index(seq_index), .seq_err(seq_err)
);

// File: tb/spi_opseq_tb.sv
module spi_opseq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_prog = '0;
    logic        tdr_wr = 1'b0, rdr_rd = 1'b0, rdr_full = 1'b0;
    logic [15:0] rdr_low = '0, cmp_val = '0, cmp_mask = '0;
    logic [7:0]  loop_lim = '0;
    logic        eng_ack = 1'b0, eng_stall = 1'b0;
    logic        eng_req, eng_first, eng_last, rdr_clr, resp_sel, seq_err;
    logic [1:0]  eng_kind, seq_state;
    logic [2:0]  shf_state, seq_index;

    int n_tests = 0, n_fail = 0, stall_arm = 0;
    int frames[$];

    always #2 clk = ~clk;

    spi_opseq u_dut (
        .clk(clk), .rst_n(rst_n), .op_prog(op_prog), .tdr_wr(tdr_wr),
        .rdr_rd(rdr_rd), .rdr_full(rdr_full), .rdr_low(rdr_low),
        .cmp_val(cmp_val), .cmp_mask(cmp_mask), .loop_lim(loop_lim),
        .eng_ack(eng_ack), .eng_stall(eng_stall), .eng_req(eng_req),
        .eng_kind(eng_kind), .eng_first(eng_first), .eng_last(eng_last),
        .rdr_clr(rdr_clr), .resp_sel(resp_sel), .seq_state(seq_state),
        .shf_state(shf_state), .seq_index(seq_index), .seq_err(seq_err)
    );

    // behavioural reference state
    int m_run, m_seq, m_shf, m_idx, m_err, m_sel, m_first, m_n1, m_held, m_op;
    int m_c[2];

    function automatic int slot(int i);
        return int'(op_prog[i*8 +: 8]);
    endfunction
    function automatic bit has_next();
        return m_idx != 7;
    endfunction
    function automatic bit m_merge();
        return has_next() && (slot(m_idx + 1) >> 4) == 4;
    endfunction
    function automatic bit m_last();
        return has_next() && slot(m_idx + 1) == 'h10;
    endfunction
    function automatic bit m_req();
        if (!(m_run == 1 && m_seq == 2)) return 1'b0;
        if ((m_op >> 4) == 3) return m_shf != 0 && m_shf != 5 && !m_merge();
        if ((m_op >> 4) == 4) return m_n1 == 1;
        return 1'b0;
    endfunction
    function automatic int m_kind();
        if ((m_op >> 4) == 4) return m_held == 1 ? 3 : 2;
        return 1;
    endfunction

    always @(posedge clk) begin : model
        bit adv, jmp, fl;
        int li;
        if (eng_req && eng_ack) frames.push_back(eng_kind * 4 + eng_first * 2 + eng_last);
        if (!rst_n) begin
            m_run = 0; m_seq = 0; m_shf = 0; m_idx = 0; m_err = 0; m_sel = 0;
            m_first = 0; m_n1 = 0; m_held = 0; m_op = 0; m_c[0] = 0; m_c[1] = 0;
        end else if (m_run == 0) begin
            if (tdr_wr || (rdr_rd && m_shf == 4)) begin
                m_run = 1; m_err = 0;
                if (m_seq == 0) m_idx = 0;
                m_seq = 1;
            end
        end else if (m_seq == 1) begin
            m_op = slot(m_idx); m_seq = 2;
        end else if (m_seq == 3) begin
            m_seq = 1;
        end else begin
            adv = 0; jmp = 0; fl = 0;
            case (m_op >> 4)
                0: begin m_c[0] = 0; m_c[1] = 0; m_shf = 0; m_seq = 0; m_run = 0; end
                1: if ((m_op & 15) == 0) begin m_sel = 0; m_shf = 5; adv = 1; end
                   else if ((m_op & 15) == 1) begin
                       m_sel = 1; m_shf = 1; m_first = 1; m_n1 = 0; m_held = 0; adv = 1;
                   end else fl = 1;
                3: if (m_shf == 0 || m_shf == 5) fl = 1;
                   else if (m_merge()) begin m_held = 1; m_n1 = 1; m_shf = 2; adv = 1; end
                   else if (eng_ack) begin m_n1 = 1; m_first = 0; m_shf = 2; adv = 1; end
                   else if (eng_stall) begin m_shf = 4; m_run = 0; end
                4: if (m_n1 == 0) fl = 1;
                   else if (eng_ack) begin m_held = 0; m_first = 0; m_shf = 3; adv = 1; end
                   else if (eng_stall) begin m_shf = 4; m_run = 0; end
                6: if (!rdr_full) begin m_shf = 4; m_run = 0; end
                   else if (((rdr_low ^ cmp_val) & ~cmp_mask) == 16'h0) adv = 1;
                   else jmp = 1;
                12: adv = 1;
                14, 15: begin
                    li = (m_op >> 4) - 14;
                    if (m_c[li] != int'(loop_lim[li*4 +: 4])) begin
                        m_c[li] = (m_c[li] + 1) % 16; jmp = 1;
                    end else adv = 1;
                end
                default: fl = 1;
            endcase
            if (fl) begin m_err = 1; m_shf = 0; m_seq = 0; m_run = 0; end
            if (jmp) begin m_idx = m_op & 7; m_seq = 3; end
            if (adv) begin
                if (m_idx == 7) begin m_run = 0; m_seq = 0; m_idx = 0; end
                else begin m_idx = m_idx + 1; m_seq = 3; end
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            chk("R1 seq_state", int'(seq_state), m_seq);
            chk("R2 seq_index", int'(seq_index), m_idx);
            chk("R3 shf_state", int'(shf_state), m_shf);
            chk("R3 resp_sel", int'(resp_sel), m_sel);
            chk("R5 seq_err", int'(seq_err), m_err);
            chk("R11 eng_req", int'(eng_req), int'(m_req()));
            chk("R8 rdr_clr", int'(rdr_clr),
                int'(m_run == 1 && m_seq == 2 && (m_op >> 4) == 6 && rdr_full));
            if (eng_req) begin
                chk("R6 eng_kind", int'(eng_kind), m_kind());
                chk("R7 eng_first", int'(eng_first), m_first);
                chk("R7 eng_last", int'(eng_last), int'(m_last()));
            end
        end
        eng_ack = 1'b0; eng_stall = 1'b0;
        if (eng_req) begin
            if (stall_arm > 0) begin eng_stall = 1'b1; stall_arm--; end
            else eng_ack = 1'b1;
        end
    endtask

    task automatic run(input logic [63:0] p, input int n);
        op_prog = p; tdr_wr = 1'b1;
        tick();
        tdr_wr = 1'b0;
        repeat (n) tick();
    endtask

    task automatic expect_frames(input string req, input int exp[$]);
        chk({req, " frame count"}, frames.size(), exp.size());
        foreach (exp[i]) if (i < frames.size()) chk({req, " frame"}, frames[i], exp[i]);
        frames.delete();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset seq_state", int'(seq_state), 0);
        chk("R3 reset shf_state", int'(shf_state), 0);
        chk("R11 reset eng_req", int'(eng_req), 0);

        // R3 R7: select, lone N1 flagged last, deselect, stop
        run(64'h0000_0000_0010_3111, 40);
        expect_frames("R7", '{7});
        chk("R4 stop shf idle", int'(shf_state), 0);
        chk("R3 deselected", int'(resp_sel), 0);

        // R6: merged N1+N2
        run(64'h0000_0000_1041_3111, 40);
        expect_frames("R6", '{15});

        // R13: skip between N1 and N2 prevents merge
        run(64'h0000_0010_41C0_3111, 50);
        expect_frames("R13", '{6, 9});

        // R5: N2 with no N1
        run(64'h0000_0000_0000_4111, 30);
        chk("R5 n2 refused", int'(seq_err), 1);
        expect_frames("R5", '{});
        // R1: error cleared on new run
        run(64'h0000_0000_0010_3111, 40);
        chk("R1 err cleared", int'(seq_err), 0);
        frames.delete();
        // R5: N1 after deselect
        run(64'h0000_0000_0000_3110, 30);
        chk("R5 n1 refused", int'(seq_err), 1);
        // R3: bad operand
        run(64'h0000_0000_0000_1211, 30);
        chk("R3 bad select err", int'(seq_err), 1);
        // R2: undefined nibble
        run(64'h0000_0000_0000_0020, 20);
        chk("R2 undefined err", int'(seq_err), 1);

        // R10: loop 1 runs N1 three times; loop 2 twice
        loop_lim = 8'h12;
        run(64'h0000_0000_10E1_3111, 120);
        expect_frames("R10 loop1", '{6, 4, 4});
        run(64'h0000_0000_10F1_3111, 120);
        expect_frames("R10 loop2", '{6, 4});
        // R4: counters cleared by stop, so loop repeats fully
        run(64'h0000_0000_10E1_3111, 120);
        expect_frames("R4 loop cleared", '{6, 4, 4});

        // R8: compare branch match / mismatch / masked
        rdr_full = 1'b1; rdr_low = 16'h1234; cmp_val = 16'h1234; cmp_mask = 16'h0;
        run(64'h0000_0000_1064_3111, 60);
        chk("R8 match steps", int'(resp_sel), 0);
        cmp_val = 16'h1235;
        run(64'h0000_0000_1064_3111, 60);
        chk("R8 mismatch jumps", int'(resp_sel), 1);
        cmp_mask = 16'h0001;
        run(64'h0000_0000_1064_3111, 60);
        chk("R8 masked match", int'(resp_sel), 0);
        frames.delete();

        // R9: compare with rdr empty waits, resumes on read
        rdr_full = 1'b0;
        run(64'h0000_0000_1064_3111, 40);
        chk("R9 waiting shf", int'(shf_state), 4);
        chk("R9 index kept", int'(seq_index), 2);
        rdr_full = 1'b1; rdr_rd = 1'b1;
        tick();
        rdr_rd = 1'b0;
        repeat (40) tick();
        chk("R9 resumed deselect", int'(resp_sel), 0);
        expect_frames("R9", '{6});

        // R11: stall then resume re-executes N1
        stall_arm = 1;
        run(64'h0000_0000_0010_3111, 40);
        chk("R11 stall waits", int'(shf_state), 4);
        expect_frames("R11 none yet", '{});
        run(64'h0000_0000_0010_3111, 40);
        expect_frames("R11 resumed", '{7});

        // R12: run past slot 7
        run(64'hC0C0_C0C0_C0C0_C011, 60);
        chk("R12 ends idle", int'(seq_state), 0);
        chk("R12 index zero", int'(seq_index), 0);
        chk("R12 no err", int'(seq_err), 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule